// File: doc/BRIEF.md
# Flash Sector ECC Syndrome Checker and Byte Corrector

This block compares the error-correcting code that was stored with a flash sector against the code newly calculated while the sector was read back. Each code is 24 bits wide. It reaches the block as three bytes on its own byte stream, and each byte comes with a valid strobe. When both codes are complete, the block forms their XOR syndrome and sorts the result into one of four classes: clean, a correctable single data-bit error, an error confined to the stored code, or uncorrectable. The class is registered together with the location of the faulty bit.

For a correctable data error, the block holds the byte index inside the sector and a one-hot mask that selects the faulty bit. A separate read-modify-write port lets the surrounding logic pass sector bytes through the block, tagged with their index. The one byte whose index matches the held error index comes back with the faulty bit flipped. Every other byte, and every byte after any other class of result, comes back unchanged. The sector buffer itself lives outside the block.

Top module: `nand_ecc_corrector`

## Requirements
- R1: Each code is assembled from three bytes on its own stream, with the first accepted byte placed in bits 7:0, the second in bits 15:8 and the third in bits 23:16. Once a stream holds three bytes, further valid bytes on that stream are ignored until the result has been produced.
- R2: Suppose the later stream's third byte is accepted at clock edge k. Then `res_valid` is low after edge k, high for exactly one cycle after edge k+1, and low again after edge k+2.
- R3: A zero syndrome gives status 2'b00 (clean), with byte index 0 and mask 0.
- R4: The syndrome's upper 12 bits and lower 12 bits may be exact complements (their XOR is 0xFFF) while syndrome bits 23:15 are below SECTOR_BYTES. In that case the status is 2'b01 (corrected data), the byte index is syndrome bits 23:15, and the mask is 1 shifted left by syndrome bits 14:12.
- R5: A syndrome with complementary halves whose byte index is not below SECTOR_BYTES gives status 2'b11 (uncorrectable), with mask 0.
- R6: A syndrome with exactly one bit set gives status 2'b10 (error in the stored code only), with mask 0, so no data is changed.
- R7: Any other nonzero syndrome gives status 2'b11, with byte index 0 and mask 0.
- R8: After reset, status, byte index and mask are all zero. Between results they keep the value last registered.
- R9: Each correction-port byte appears on `fix_out_byte` with `fix_out_valid` high one cycle after `fix_in_valid`. The output byte is the input XORed with the held mask when the input index equals the held byte index, and is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stored_byte | input | 8 | Byte of the code read from the spare area |
| stored_valid | input | 1 | Strobe for `stored_byte` |
| calc_byte | input | 8 | Byte of the freshly calculated code |
| calc_valid | input | 1 | Strobe for `calc_byte` |
| res_valid | output | 1 | One-cycle pulse: a new result is registered |
| res_status | output | 2 | 00 clean, 01 corrected data, 10 code-only error, 11 uncorrectable |
| res_byte_idx | output | 9 | Byte index of the faulty data bit (valid with status 01) |
| res_bit_mask | output | 8 | One-hot mask of the faulty bit (zero unless status 01) |
| fix_in_valid | input | 1 | Strobe for a byte on the correction port |
| fix_in_idx | input | 9 | Sector index of the byte presented |
| fix_in_byte | input | 8 | Data byte presented for correction |
| fix_out_valid | output | 1 | Corrected byte is valid |
| fix_out_byte | output | 8 | Byte after the conditional bit flip |

## Verification
The hardest case to reach from the ports is a syndrome with complementary halves, because it needs the two codes to differ in exactly the right twelve-plus bits. The hardest version of that case is one whose byte index runs past the sector end, which needs a sector size below the index range. The bench builds the instance with a 384-byte sector. It sweeps all 4096 complementary syndromes, laid over pseudo-random base codes, so both in-range and out-of-range indices occur, and it patches the flagged byte on every in-range case. Codes arrive in three orderings: lock-step, stored-first with stray bytes on the full stream, and calculated-first with idle gaps. This exercises the completion timing and the rule that bytes on a full stream are ignored.

// File: rtl/ecc_fix_pkg.sv
// Shared types for the sector ECC checker.
// Assumes a two-bit status code whose values are fixed by the requirements.
package ecc_fix_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN     = 2'b00,
        ST_FIXED     = 2'b01,
        ST_CODE_ONLY = 2'b10,
        ST_UNCORR    = 2'b11
    } ecc_status_t;
endpackage

// File: rtl/ecc_code_assembler.sv
// Collects NBYTES bytes from one strobed stream into a code word, first byte
// in the least significant slot. Raises full when complete and ignores
// further bytes until clear. Assumes clear is asserted only while full.
module ecc_code_assembler #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BYTE_W-1:0]        in_byte,
    input  logic                     in_valid,
    input  logic                     clear,
    output logic [NBYTES*BYTE_W-1:0] code,
    output logic                     full
);
    localparam int CNT_W = $clog2(NBYTES + 1);

    logic [CNT_W-1:0] cnt;
    logic             take;

    assign full = (cnt == CNT_W'(NBYTES));
    assign take = in_valid && !full;

    // Byte counter: advances on each accepted byte, restarts on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (take)       cnt <= cnt + 1'b1;
    end

    // One slot register per byte position; a slot loads when the count points at it.
    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                          code[g*BYTE_W +: BYTE_W] <= '0;
            else if (take && cnt == CNT_W'(g))   code[g*BYTE_W +: BYTE_W] <= in_byte;
        end
    end

    // A full code stays intact until the result consumes it.
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clear |=> full && $stable(code));
endmodule

// File: rtl/ecc_syndrome_classifier.sv
// Combinational classification of a code-word syndrome into the four
// result classes, with the error location for a correctable data bit.
// Assumes the upper and lower halves of the code are equal in width.
module ecc_syndrome_classifier
    import ecc_fix_pkg::*;
#(
    parameter int CODE_W       = 24,
    parameter int BYTE_W       = 8,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0]                   syndrome,
    output ecc_status_t                         status,
    output logic [CODE_W-CODE_W/2-$clog2(BYTE_W)-1:0] byte_idx,
    output logic [BYTE_W-1:0]                   bit_mask
);
    localparam int HALF_W = CODE_W / 2;
    localparam int POS_W  = $clog2(BYTE_W);
    localparam int IDX_W  = CODE_W - HALF_W - POS_W;

    logic [HALF_W-1:0] lo_half, hi_half;
    logic              halves_cmpl;
    logic [IDX_W-1:0]  cand_idx;
    logic [POS_W-1:0]  cand_pos;
    logic              in_range;

    // Split the syndrome and derive the candidate location.
    always_comb begin
        lo_half     = syndrome[HALF_W-1:0];
        hi_half     = syndrome[CODE_W-1:HALF_W];
        halves_cmpl = ((hi_half ^ lo_half) == {HALF_W{1'b1}});
        cand_idx    = syndrome[CODE_W-1 -: IDX_W];
        cand_pos    = syndrome[HALF_W +: POS_W];
        in_range    = (32'(cand_idx) < SECTOR_BYTES);
    end

    // Priority decision: zero, complementary halves, single bit, otherwise.
    always_comb begin
        status   = ST_CLEAN;
        byte_idx = '0;
        bit_mask = '0;
        if (syndrome == '0) begin
            status = ST_CLEAN;
        end else if (halves_cmpl) begin
            if (in_range) begin
                status   = ST_FIXED;
                byte_idx = cand_idx;
                bit_mask = BYTE_W'(1) << cand_pos;
            end else begin
                status = ST_UNCORR;
            end
        end else if ($onehot(syndrome)) begin
            status = ST_CODE_ONLY;
        end else begin
            status = ST_UNCORR;
        end
    end
endmodule

// File: rtl/ecc_byte_patcher.sv
// Registered read-modify-write stage: flips the held error bit in the byte
// whose index matches the held error index. Assumes the mask is zero
// whenever no data correction is pending.
module ecc_byte_patcher #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  err_idx,
    input  logic [BYTE_W-1:0] err_mask,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    // Output register: pass the byte through, XOR the mask on an index hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_byte <= (in_idx == err_idx) ? (in_byte ^ err_mask) : in_byte;
        end
    end

    p_fix_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_fix_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_idx != err_idx) |=> out_byte == $past(in_byte));
endmodule

// File: rtl/nand_ecc_corrector.sv
// Top level: assembles the stored and calculated codes, registers the
// syndrome class and error location once both are complete, and offers a
// correction port for sector bytes. Assumes a full stream gets no new bytes
// in the cycle the result is taken (those bytes are dropped).
module nand_ecc_corrector
    import ecc_fix_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int CODE_BYTES   = 3,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W      = BYTE_W * CODE_BYTES,
    localparam int IDX_W       = CODE_W - CODE_W / 2 - $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] stored_byte,
    input  logic              stored_valid,
    input  logic [BYTE_W-1:0] calc_byte,
    input  logic              calc_valid,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [IDX_W-1:0]  res_byte_idx,
    output logic [BYTE_W-1:0] res_bit_mask,
    input  logic              fix_in_valid,
    input  logic [IDX_W-1:0]  fix_in_idx,
    input  logic [BYTE_W-1:0] fix_in_byte,
    output logic              fix_out_valid,
    output logic [BYTE_W-1:0] fix_out_byte
);
    logic [CODE_W-1:0] stored_code, calc_code, syndrome;
    logic              stored_full, calc_full, take_result;
    ecc_status_t       cls_status;
    logic [IDX_W-1:0]  cls_idx;
    logic [BYTE_W-1:0] cls_mask;

    assign take_result = stored_full && calc_full;
    assign syndrome    = stored_code ^ calc_code;

    ecc_code_assembler #(.BYTE_W(BYTE_W), .NBYTES(CODE_BYTES)) stored_asm_i (
        .clk(clk), .rst_n(rst_n), .in_byte(stored_byte), .in_valid(stored_valid),
        .clear(take_result), .code(stored_code), .full(stored_full));

    ecc_code_assembler #(.BYTE_W(BYTE_W), .NBYTES(CODE_BYTES)) calc_asm_i (
        .clk(clk), .rst_n(rst_n), .in_byte(calc_byte), .in_valid(calc_valid),
        .clear(take_result), .code(calc_code), .full(calc_full));

    ecc_syndrome_classifier #(.CODE_W(CODE_W), .BYTE_W(BYTE_W),
                              .SECTOR_BYTES(SECTOR_BYTES)) classify_i (
        .syndrome(syndrome), .status(cls_status),
        .byte_idx(cls_idx), .bit_mask(cls_mask));

    // Result register: captures the class once both codes are complete and holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_status   <= ST_CLEAN;
            res_byte_idx <= '0;
            res_bit_mask <= '0;
        end else begin
            res_valid <= take_result;
            if (take_result) begin
                res_status   <= cls_status;
                res_byte_idx <= cls_idx;
                res_bit_mask <= cls_mask;
            end
        end
    end

    ecc_byte_patcher #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) patch_i (
        .clk(clk), .rst_n(rst_n), .err_idx(res_byte_idx), .err_mask(res_bit_mask),
        .in_valid(fix_in_valid), .in_idx(fix_in_idx), .in_byte(fix_in_byte),
        .out_valid(fix_out_valid), .out_byte(fix_out_byte));

    p_res_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_status == ST_FIXED |-> $countones(res_bit_mask) == 1);
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_status == ST_FIXED |-> 32'(res_byte_idx) < SECTOR_BYTES);
    p_no_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_status != ST_FIXED |-> res_bit_mask == '0);
endmodule

// File: tb/nand_ecc_corrector_tb.sv
module nand_ecc_corrector_tb_top;
    localparam int SECTOR = 384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] stored_byte = '0, calc_byte = '0, fix_in_byte = '0;
    logic       stored_valid = 1'b0, calc_valid = 1'b0, fix_in_valid = 1'b0;
    logic [8:0] fix_in_idx = '0;
    logic       res_valid, fix_out_valid;
    logic [1:0] res_status;
    logic [8:0] res_byte_idx;
    logic [7:0] res_bit_mask, fix_out_byte;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    logic [23:0] lfsr = 24'hACE1B5;

    nand_ecc_corrector #(.SECTOR_BYTES(SECTOR)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .stored_byte(stored_byte), .stored_valid(stored_valid),
        .calc_byte(calc_byte), .calc_valid(calc_valid),
        .res_valid(res_valid), .res_status(res_status),
        .res_byte_idx(res_byte_idx), .res_bit_mask(res_bit_mask),
        .fix_in_valid(fix_in_valid), .fix_in_idx(fix_in_idx), .fix_in_byte(fix_in_byte),
        .fix_out_valid(fix_out_valid), .fix_out_byte(fix_out_byte));

    always #5 clk = ~clk;

    // Watchdog: counts as a miscompare and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
    endtask

    // Expected class from the requirements: {status, idx, mask}.
    function automatic logic [18:0] expect_of(input logic [23:0] s);
        logic [11:0] lo, hi;
        logic [8:0]  idx;
        lo  = s[11:0];
        hi  = s[23:12];
        idx = s[23:15];
        if (s == 24'd0)                     return {2'b00, 9'd0, 8'd0};
        if ((hi ^ lo) == 12'hFFF) begin
            if (int'(idx) < SECTOR)         return {2'b01, idx, 8'd1 << s[14:12]};
            return {2'b11, 9'd0, 8'd0};
        end
        if ($countones(s) == 1)             return {2'b10, 9'd0, 8'd0};
        return {2'b11, 9'd0, 8'd0};
    endfunction

    // Drive both codes in one of three orderings, then check timing and result.
    task automatic run_pair(input logic [23:0] sc, input logic [23:0] cc, input int order);
        logic [18:0] e;
        e = expect_of(sc ^ cc);
        if (order == 0) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                stored_valid = 1'b1; stored_byte = sc[i*8 +: 8];
                calc_valid   = 1'b1; calc_byte   = cc[i*8 +: 8];
            end
        end else if (order == 1) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                stored_valid = 1'b1; stored_byte = sc[i*8 +: 8];
            end
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                stored_valid = 1'b1; stored_byte = ~sc[i*8 +: 8] ^ 8'h5A; // stray, R1
                calc_valid   = 1'b1; calc_byte   = cc[i*8 +: 8];
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                calc_valid = 1'b1; calc_byte = cc[i*8 +: 8];
                @(negedge clk);
                calc_valid = 1'b0;
            end
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                calc_valid   = 1'b1; calc_byte = 8'hC3;   // stray on full stream, R1
                stored_valid = 1'b1; stored_byte = sc[i*8 +: 8];
            end
        end
        @(negedge clk);
        stored_valid = 1'b0; calc_valid = 1'b0;
        chk("R2 no result yet", 32'(res_valid), 32'd0);
        @(negedge clk);
        chk("R2 result pulse", 32'(res_valid), 32'd1);
        chk("R3/R4/R5/R6/R7 status", 32'(res_status), 32'(e[18:17]));
        chk("R4 byte index", 32'(res_byte_idx), 32'(e[16:8]));
        chk("R4 bit mask", 32'(res_bit_mask), 32'(e[7:0]));
        @(negedge clk);
        chk("R2 pulse ends", 32'(res_valid), 32'd0);
        chk("R8 status held", 32'(res_status), 32'(e[18:17]));
    endtask

    task automatic fix_try(input logic [8:0] idx, input logic [7:0] b, input logic [7:0] exp);
        @(negedge clk);
        fix_in_valid = 1'b1; fix_in_idx = idx; fix_in_byte = b;
        @(negedge clk);
        fix_in_valid = 1'b0;
        chk("R9 fix valid", 32'(fix_out_valid), 32'd1);
        chk("R9 fix byte", 32'(fix_out_byte), 32'(exp));
    endtask

    initial begin
        logic [23:0] s, base;
        logic [18:0] e;
        repeat (5) @(negedge clk);
        chk("R8 reset status", 32'(res_status), 32'd0);
        chk("R8 reset index", 32'(res_byte_idx), 32'd0);
        chk("R8 reset mask", 32'(res_bit_mask), 32'd0);
        chk("R2 reset valid", 32'(res_valid), 32'd0);
        rst_n = 1'b1;

        // Zero syndrome over three orderings.
        for (int o = 0; o < 3; o++) begin
            step_lfsr();
            run_pair(lfsr, lfsr, o);
            fix_try(9'd0, lfsr[7:0], lfsr[7:0]); // R3: no correction
        end

        // R1 byte order: a single-bit syndrome in byte 0 bit 0 must read as code-only.
        run_pair(24'h000001, 24'h000000, 1);
        chk("R1 low byte first", 32'(res_status), 32'd2);

        // R6: every single-bit syndrome.
        for (int b = 0; b < 24; b++) begin
            step_lfsr();
            run_pair(lfsr, lfsr ^ (24'd1 << b), b % 3);
            fix_try(lfsr[8:0], 8'hFF, 8'hFF);
        end

        // R4/R5: all complementary syndromes over pseudo-random base codes.
        for (int lo = 0; lo < 4096; lo++) begin
            step_lfsr();
            base = lfsr;
            s = {~lo[11:0], lo[11:0]};
            run_pair(base, base ^ s, lo % 3);
            e = expect_of(s);
            if (e[18:17] == 2'b01) begin
                fix_try(s[23:15], base[7:0], base[7:0] ^ (8'd1 << s[14:12]));
                fix_try(s[23:15] ^ 9'd1, base[15:8], base[15:8]);
            end
        end

        // R7: other nonzero syndromes.
        for (int n = 0; n < 1500; n++) begin
            step_lfsr();
            base = lfsr;
            step_lfsr();
            s = lfsr | 24'h000300; // at least two bits set
            run_pair(base, base ^ s, n % 3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule